// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Line Transmitter

This block turns a stream of 16-bit stereo PCM sample pairs into a single serial line signal in the IEC 60958 consumer audio style. It runs from a free-running system clock and advances one line cell on each cycle where `cell_en` is high. The enable is expected at 128 times the audio sample rate, which is about 5.6448 MHz for 44.1 kHz material. Every frame is 128 cells long. It carries a left subframe and then a right subframe, and each subframe has 32 slots of two cells each.

At the first cell of every frame the block offers `smp_ready`. If `smp_valid` is high in that cycle, the pair on `smp_left`/`smp_right` is latched and held for the whole frame, together with the current `mute` level. If no pair is offered, the frame still goes out, fully formed, with zero audio. Slots 0–3 of each subframe hold the 8-cell sync preamble. The data slots use biphase-mark coding. Parity is always made even by a correction bit placed in the first auxiliary slot, so the parity slot itself always goes out as 0. Muting sets only the validity slot.

Top module: `spdif_bmc_tx`

## Requirements
- R1: While reset is applied and after it is released, `line_out` is 0. The first frame after reset uses the block-start preamble on its left subframe.
- R2: `smp_ready` is high exactly on `cell_en` cycles at cell 0 of a frame. The pair and `mute` sampled in that cycle are used for the whole frame, and input changes later in the frame have no effect.
- R3: Each subframe begins with an 8-cell preamble, sent first cell first, for a preceding line level of 0. The block-start preamble is 11101000, the left preamble is 11100010 and the right preamble is 11100100. All three are inverted when the preceding level is 1. The left subframe always comes before the right one.
- R4: The block-start preamble replaces the left preamble on one frame in every `BLOCK_FRAMES` frames (default 192), starting with the first frame.
- R5: In slots 4–31 the line toggles at the start of every slot, and toggles again at mid-slot exactly when the slot bit is 1.
- R6: Sample bit k is sent in slot 12+k, so the LSB goes first in slot 12 and the MSB in slot 27. Slots 5–11 are 0.
- R7: Slot 28 (validity) carries the latched `mute` level. Slot 29 (user), slot 30 (channel status) and slot 31 (parity) are 0.
- R8: Slot 4 makes the number of 1 bits over slots 4–31 even. As a result the line returns to level 0 at every subframe boundary.
- R9: A frame whose cell-0 cycle has `smp_valid` low is sent with a zero sample on both channels. Frames continue without a gap.
- R10: `line_out` changes only on the clock edge that follows a `cell_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | Line-cell advance strobe, 128 x fs |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pair accepted this cycle (frame start) |
| smp_left | input | SAMPLE_W | Left channel sample |
| smp_right | input | SAMPLE_W | Right channel sample |
| mute | input | 1 | Flag the frame's audio as not valid |
| line_out | output | 1 | Biphase-mark coded line signal |

## Verification
`line_out` is a register, so the value for a cell is visible on the clock edge where `cell_en` was sampled high. The bench therefore pulses `cell_en` for one clock and reads the line at the following falling edge. `smp_ready` is a combinational result of `cell_en` and the cell position, so the bench checks it in the same cycle, before that edge. Latched samples first affect the line at cell 8 of their own frame. The bench collects 64 cells for each subframe and decodes them after the last cell arrives. It then compares the decoded preamble, slot bits and sample against values taken when the frame started. After cell 0 it scrambles the inputs, which shows that later input changes have no effect.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int CELLS_PER_FRAME = 128;
  localparam int CELL_W          = $clog2(CELLS_PER_FRAME);
  localparam int SLOT_W          = 5;
  localparam int SYNC_SLOTS      = 4;
  localparam int PAYLOAD_SLOTS   = 32 - SYNC_SLOTS;

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_LEFT  = 2'd1,
    SYNC_RIGHT = 2'd2
  } sync_kind_t;

  // Cell patterns for a preceding line level of 0, first cell in bit 7.
  function automatic logic [7:0] sync_pattern(input sync_kind_t kind);
    case (kind)
      SYNC_BLOCK: sync_pattern = 8'b1110_1000;
      SYNC_LEFT:  sync_pattern = 8'b1110_0010;
      default:    sync_pattern = 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/spdif_cell_seq.sv
module spdif_cell_seq
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_en,
  output logic [CELL_W-1:0] cell_idx,
  output logic              block_first
);

  localparam int FRM_W = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1;
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(BLOCK_FRAMES - 1);

  logic [FRM_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_idx <= '0;
      frame_q  <= '0;
    end else if (cell_en) begin
      cell_idx <= cell_idx + 1'b1;
      if (cell_idx == '1)
        frame_q <= (frame_q == FRM_LAST) ? '0 : frame_q + 1'b1;
    end
  end

  assign block_first = (frame_q == '0);

  // R4: the frame counter wraps exactly after the last frame of a block
  a_r4_block_wrap: assert property (@(posedge clk) disable iff (rst)
    (cell_en && cell_idx == '1 && frame_q == FRM_LAST) |=> block_first);

  a_r4_frame_range: assert property (@(posedge clk) disable iff (rst)
    frame_q <= FRM_LAST);

endmodule

// File: rtl/spdif_slot_map.sv
module spdif_slot_map
  import spdif_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [CELL_W-1:0]   cell_idx,
  input  logic                block_first,
  input  logic [SAMPLE_W-1:0] left_q,
  input  logic [SAMPLE_W-1:0] right_q,
  input  logic                invalid_q,
  output logic                sync_active,
  output logic                sync_first,
  output logic                sync_bit,
  output logic                half_second,
  output logic                data_bit
);

  // Payload index 0 is slot 4; the sample ends just below the validity slot.
  localparam int AUD_LO = PAYLOAD_SLOTS - 4 - SAMPLE_W;
  localparam int V_IDX  = PAYLOAD_SLOTS - 4;

  logic                     right_sub;
  logic [SLOT_W-1:0]        slot;
  logic [SLOT_W-1:0]        pidx;
  logic [2:0]               sync_pos;
  sync_kind_t               kind;
  logic [7:0]               pattern;
  logic [SAMPLE_W-1:0]      smp;
  logic [PAYLOAD_SLOTS-1:0] payload;

  assign right_sub   = cell_idx[CELL_W-1];
  assign slot        = cell_idx[CELL_W-2:1];
  assign half_second = cell_idx[0];
  assign sync_active = (slot < SLOT_W'(SYNC_SLOTS));
  assign sync_first  = (cell_idx[CELL_W-2:0] == '0);
  assign sync_pos    = cell_idx[2:0];

  assign kind    = right_sub ? SYNC_RIGHT : (block_first ? SYNC_BLOCK : SYNC_LEFT);
  assign pattern = sync_pattern(kind);
  assign sync_bit = pattern[3'd7 - sync_pos];

  assign smp = right_sub ? right_q : left_q;

  always_comb begin
    payload                        = '0;
    payload[AUD_LO +: SAMPLE_W]    = smp;
    payload[V_IDX]                 = invalid_q;
    payload[0]                     = (^smp) ^ invalid_q;
  end

  assign pidx     = slot - SLOT_W'(SYNC_SLOTS);
  assign data_bit = sync_active ? 1'b0 : payload[pidx];

endmodule

// File: rtl/spdif_bmc_coder.sv
module spdif_bmc_coder (
  input  logic clk,
  input  logic rst,
  input  logic cell_en,
  input  logic sync_active,
  input  logic sync_first,
  input  logic sync_bit,
  input  logic half_second,
  input  logic data_bit,
  output logic line_out
);

  logic inv_q;
  logic inv;
  logic line_nxt;

  // Level before the preamble decides its polarity.
  assign inv = sync_first ? line_out : inv_q;

  always_comb begin
    if (sync_active)
      line_nxt = sync_bit ^ inv;
    else if (!half_second)
      line_nxt = ~line_out;
    else
      line_nxt = data_bit ? ~line_out : line_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b0;
      inv_q    <= 1'b0;
    end else if (cell_en) begin
      line_out <= line_nxt;
      if (sync_first)
        inv_q <= line_out;
    end
  end

  // R10: the line only moves on cell strobes
  a_r10_line_hold: assert property (@(posedge clk) disable iff (rst)
    !cell_en |=> $stable(line_out));

  // R5: every data slot opens with a transition
  a_r5_slot_edge: assert property (@(posedge clk) disable iff (rst)
    (cell_en && !sync_active && !half_second) |=> (line_out != $past(line_out)));

  // R3: every preamble opens with a transition
  a_r3_sync_lead: assert property (@(posedge clk) disable iff (rst)
    (cell_en && sync_first) |=> (line_out != $past(line_out)));

  // R8: even payload parity brings the line back to 0 at each subframe start
  a_r8_level_return: assert property (@(posedge clk) disable iff (rst)
    (cell_en && sync_first) |-> (line_out == 1'b0));

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_tx_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_en,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mute,
  output logic                line_out
);

  logic [CELL_W-1:0]   cell_idx;
  logic                block_first;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic                invalid_q;
  logic                sync_active;
  logic                sync_first;
  logic                sync_bit;
  logic                half_second;
  logic                data_bit;

  spdif_cell_seq #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cell_en     (cell_en),
    .cell_idx    (cell_idx),
    .block_first (block_first)
  );

  assign smp_ready = cell_en && (cell_idx == '0);

  // Frame-start capture; held until the next frame start.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      right_q   <= '0;
      invalid_q <= 1'b0;
    end else if (smp_ready) begin
      left_q    <= smp_valid ? smp_left  : '0;
      right_q   <= smp_valid ? smp_right : '0;
      invalid_q <= mute;
    end
  end

  spdif_slot_map #(.SAMPLE_W(SAMPLE_W)) u_map (
    .cell_idx    (cell_idx),
    .block_first (block_first),
    .left_q      (left_q),
    .right_q     (right_q),
    .invalid_q   (invalid_q),
    .sync_active (sync_active),
    .sync_first  (sync_first),
    .sync_bit    (sync_bit),
    .half_second (half_second),
    .data_bit    (data_bit)
  );

  spdif_bmc_coder u_coder (
    .clk         (clk),
    .rst         (rst),
    .cell_en     (cell_en),
    .sync_active (sync_active),
    .sync_first  (sync_first),
    .sync_bit    (sync_bit),
    .half_second (half_second),
    .data_bit    (data_bit),
    .line_out    (line_out)
  );

  // R2: acceptance only on a cell strobe
  a_r2_ready_strobe: assert property (@(posedge clk) disable iff (rst)
    smp_ready |-> cell_en);

  // R2: captured pair does not move mid-frame
  a_r2_pair_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_ready |=> ($stable(left_q) && $stable(right_q) && $stable(invalid_q)));

endmodule

// File: tb/spdif_bmc_tx_test.sv
module spdif_bmc_tx_test;

  localparam int SW     = 16;
  localparam int BLK    = 8;
  localparam int FRAMES = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cell_en = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [SW-1:0] smp_left = '0;
  logic [SW-1:0] smp_right = '0;
  logic          mute = 1'b0;
  logic          line_out;

  int n_checks = 0;
  int n_fails  = 0;

  logic          cells [0:63];
  logic          prev_lvl;
  logic [SW-1:0] exp_l, exp_r;
  logic          exp_v;

  always #5 clk = ~clk;

  spdif_bmc_tx #(.SAMPLE_W(SW), .BLOCK_FRAMES(BLK)) uut (
    .clk(clk), .rst(rst), .cell_en(cell_en), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .mute(mute), .line_out(line_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  function automatic logic [SW-1:0] pick(input int f, input int ch);
    case (f)
      0: pick = ch ? 16'hFFFF : 16'h0000;
      1: pick = ch ? 16'h0001 : 16'h8000;
      2: pick = ch ? 16'h5555 : 16'hAAAA;
      default: pick = SW'(f * 16'h1357) ^ (ch ? 16'hA5C3 : 16'h0F1E);
    endcase
  endfunction

  function automatic bit valid_for(input int f);
    return !(f == 3 || f == 4 || f == 11);
  endfunction

  function automatic bit mute_for(input int f);
    return (f == 5 || f == 6 || f == 13 || f == 3);
  endfunction

  task automatic decode(input int f, input int sub);
    logic [7:0]  got_pre, exp_pre;
    logic [31:0] bits;
    logic [SW-1:0] got_s, want_s;
    bit edges_ok;
    int ones;
    bits = '0;
    for (int i = 0; i < 8; i++) got_pre[7-i] = cells[i];
    if (sub == 1)          exp_pre = 8'b1110_0100;
    else if (f % BLK == 0) exp_pre = 8'b1110_1000;
    else                   exp_pre = 8'b1110_0010;
    exp_pre = exp_pre ^ {8{prev_lvl}};
    // R3 pattern and order, R4 block period
    check(got_pre == exp_pre, (sub == 0 && f % BLK == 0) ? "R4" : "R3",
          "preamble", int'(got_pre), int'(exp_pre));
    edges_ok = 1'b1;
    for (int s = 4; s < 32; s++) begin
      if (cells[2*s] == cells[2*s-1]) edges_ok = 1'b0;
      bits[s] = cells[2*s] ^ cells[2*s+1];
    end
    check(edges_ok, "R5", "slot-start transitions", int'(edges_ok), 1);
    for (int k = 0; k < SW; k++) got_s[k] = bits[12+k];
    want_s = (sub == 0) ? exp_l : exp_r;
    check(got_s == want_s, valid_for(f) ? "R6" : "R9", "sample", int'(got_s), int'(want_s));
    check(bits[11:5] == '0, "R6", "aux/unused slots", int'(bits[11:5]), 0);
    check(bits[28] == exp_v, "R7", "validity slot", int'(bits[28]), int'(exp_v));
    check(bits[31:29] == '0, "R7", "U/C/P slots", int'(bits[31:29]), 0);
    ones = $countones(bits[31:4]);
    check(ones % 2 == 0, "R8", "slot 4-31 parity", ones % 2, 0);
    check(cells[63] == 1'b0, "R8", "end level", int'(cells[63]), 0);
    prev_lvl = cells[63];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    prev_lvl = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(line_out == 1'b0, "R1", "line during reset", int'(line_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(line_out == 1'b0, "R1", "line after reset", int'(line_out), 0);
    check(smp_ready == 1'b0, "R2", "ready without strobe", int'(smp_ready), 0);
    for (int f = 0; f < FRAMES; f++) begin
      for (int c = 0; c < 128; c++) begin
        if (c == 0) begin
          smp_valid = valid_for(f);
          smp_left  = pick(f, 0);
          smp_right = pick(f, 1);
          mute      = mute_for(f);
          exp_l     = smp_valid ? smp_left  : '0;
          exp_r     = smp_valid ? smp_right : '0;
          exp_v     = mute;
        end
        cell_en = 1'b1;
        #1;
        if (c == 0 || c == 1)
          check(smp_ready == (c == 0), "R2", "ready at frame cell", int'(smp_ready), int'(c == 0));
        @(negedge clk);
        cell_en = 1'b0;
        if (c == 1) begin
          // R2: changes after acceptance must not reach this frame
          smp_valid = 1'b1;
          smp_left  = ~smp_left;
          smp_right = ~smp_right ^ 16'h0100;
          mute      = ~mute;
        end
        cells[c % 64] = line_out;
        if (c == 63)  decode(f, 0);
        if (c == 127) decode(f, 1);
        @(negedge clk);
      end
    end
    finish_run();
  end

endmodule